// File: doc/BRIEF.md
# Product-Term Sum Cell with Cascade

This block is the combinational front half of one programmable logic cell. A set of input lines, formed from a global bus and a regional bus, feeds five product terms. Each term is an AND of literals picked by two programming masks: one enables the true form of a line, the other enables its complement. A per-term steering bit sends each term either into the cell's OR sum or out on an auxiliary output, where a later register stage can use it for control or alternate data.

The OR sum also takes a cascade input from a neighbouring cell. The sum leaves the cell unchanged on the cascade output, so cells can be chained. Eight cells of five terms give one sum of up to 40 terms. An XOR stage then combines the sum with a selectable second input. That input is constant low, constant high, or one chosen product term. The constant settings act as an output polarity control, and the product-term setting supports compare and arithmetic functions. All programming inputs are expected to be held static by configuration registers outside this block.

Top module: `mc_sum_cell`

## Requirements
- R1: Line index j (0 to GLB_W+RGN_W-1) is global bit j when j < GLB_W, otherwise regional bit j-GLB_W. Product term k reads bit k*LINE_W+j of `tru_mask_i` (true literal) and of `cmp_mask_i` (complement literal). A term is 1 exactly when every enabled true literal's line is 1 and every enabled complement literal's line is 0.
- R2: A term with no literal enabled in either mask evaluates to 1.
- R3: A term that enables both the true and the complement literal of the same line evaluates to 0.
- R4: `steer_i[k]` = 0 routes term k to the OR sum and forces `aux_o[k]` to 0. `steer_i[k]` = 1 drives `aux_o[k]` with the term's value and removes the term from the sum.
- R5: `casc_o` equals the OR of `casc_i` and every term steered to the sum. It is 0 when no steered term is 1 and `casc_i` is 0.
- R6: With `xsel_i` = 2'b00 or 2'b11, `xor_o` equals `casc_o`. With 2'b01, `xor_o` is the inverse of `casc_o`.
- R7: With `xsel_i` = 2'b10, `xor_o` equals `casc_o` XOR product term XT_IDX (default 4). The term's raw value is used whatever its steering.
- R8: `casc_i` = 1 forces `casc_o` to 1 under every configuration, so a sum carried along a chain is never lost.
- R9: Over random configurations and inputs, all outputs match a sum-of-products reference model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_i | input | GLB_W | Global bus lines |
| rgn_i | input | RGN_W | Regional bus lines |
| tru_mask_i | input | NUM_TERMS*LINE_W | True-literal enables, one LINE_W slice per term |
| cmp_mask_i | input | NUM_TERMS*LINE_W | Complement-literal enables, one slice per term |
| steer_i | input | NUM_TERMS | Per-term steering: 0 to sum, 1 to auxiliary |
| xsel_i | input | 2 | XOR second-input select |
| casc_i | input | 1 | Cascade sum from the neighbouring cell |
| casc_o | output | 1 | This cell's OR sum, before the XOR |
| xor_o | output | 1 | XOR stage result |
| aux_o | output | NUM_TERMS | Terms steered away from the sum |

## Verification
The assertions check the structural relations on every evaluation: cascade dominance, exclusive steering between sum and auxiliary outputs, the OR sum against the exposed term values, constant-polarity behaviour of the XOR, and empty terms evaluating high. Whether each term decodes the right line, with the right bit position and literal polarity, can only be shown by the bench's directed scenarios and its independent sum-of-products model under random programming. The same holds for the XOR's product-term input selecting the right term.

// File: rtl/mc_sum_pkg.sv
package mc_sum_pkg;

  typedef enum logic [1:0] {
    XSEL_ZERO = 2'b00,
    XSEL_ONE  = 2'b01,
    XSEL_TERM = 2'b10,
    XSEL_RSVD = 2'b11
  } xsel_e;

  localparam logic STEER_SUM = 1'b0;
  localparam logic STEER_AUX = 1'b1;

  // AND of enabled literals: a line fails a true literal when 0,
  // fails a complement literal when 1.
  function automatic logic pterm_and(input logic [255:0] line,
                                     input logic [255:0] tmask,
                                     input logic [255:0] cmask);
    logic [255:0] miss;
    miss = (tmask & ~line) | (cmask & line);
    return ~(|miss);
  endfunction

  function automatic logic xor_second(input logic [1:0] xsel, input logic term);
    case (xsel)
      XSEL_ONE:  return 1'b1;
      XSEL_TERM: return term;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mc_pterm.sv
module mc_pterm #(
  parameter int LINE_W = 24
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] tmask_i,
  input  logic [LINE_W-1:0] cmask_i,
  output logic              term_o
);
  import mc_sum_pkg::*;

  logic [255:0] line_x, tmask_x, cmask_x;

  always_comb begin
    line_x  = '0;
    tmask_x = '0;
    cmask_x = '0;
    line_x[LINE_W-1:0]  = line_i;
    tmask_x[LINE_W-1:0] = tmask_i;
    cmask_x[LINE_W-1:0] = cmask_i;
    term_o = pterm_and(line_x, tmask_x, cmask_x);
  end
endmodule

// File: rtl/mc_steer.sv
module mc_steer #(
  parameter int NUM_TERMS = 5
) (
  input  logic [NUM_TERMS-1:0] term_i,
  input  logic [NUM_TERMS-1:0] steer_i,
  input  logic                 casc_i,
  output logic                 sum_o,
  output logic [NUM_TERMS-1:0] aux_o
);
  import mc_sum_pkg::*;

  logic [NUM_TERMS-1:0] to_sum;

  for (genvar k = 0; k < NUM_TERMS; k++) begin : g_mux
    assign to_sum[k] = (steer_i[k] == STEER_SUM) ? term_i[k] : 1'b0;
    assign aux_o[k]  = (steer_i[k] == STEER_AUX) ? term_i[k] : 1'b0;
  end

  assign sum_o = (|to_sum) | casc_i;
endmodule

// File: rtl/mc_xor_stage.sv
module mc_xor_stage (
  input  logic       sum_i,
  input  logic       term_i,
  input  logic [1:0] xsel_i,
  output logic       out_o
);
  import mc_sum_pkg::*;

  assign out_o = sum_i ^ xor_second(xsel_i, term_i);
endmodule

// File: rtl/mc_sum_cell.sv
module mc_sum_cell #(
  parameter int NUM_TERMS = 5,
  parameter int GLB_W     = 16,
  parameter int RGN_W     = 8,
  parameter int XT_IDX    = 4,
  localparam int LINE_W   = GLB_W + RGN_W,
  localparam int MASK_W   = NUM_TERMS * LINE_W
) (
  input  logic [GLB_W-1:0]     glb_i,
  input  logic [RGN_W-1:0]     rgn_i,
  input  logic [MASK_W-1:0]    tru_mask_i,
  input  logic [MASK_W-1:0]    cmp_mask_i,
  input  logic [NUM_TERMS-1:0] steer_i,
  input  logic [1:0]           xsel_i,
  input  logic                 casc_i,
  output logic                 casc_o,
  output logic                 xor_o,
  output logic [NUM_TERMS-1:0] aux_o
);

  logic [LINE_W-1:0]    line_w;
  logic [NUM_TERMS-1:0] pt_val;   // raw product-term values, exposed for checks

  assign line_w = {rgn_i, glb_i};

  for (genvar k = 0; k < NUM_TERMS; k++) begin : g_term
    mc_pterm #(.LINE_W(LINE_W)) u_pterm (
      .line_i  (line_w),
      .tmask_i (tru_mask_i[k*LINE_W +: LINE_W]),
      .cmask_i (cmp_mask_i[k*LINE_W +: LINE_W]),
      .term_o  (pt_val[k])
    );
  end

  mc_steer #(.NUM_TERMS(NUM_TERMS)) u_steer (
    .term_i  (pt_val),
    .steer_i (steer_i),
    .casc_i  (casc_i),
    .sum_o   (casc_o),
    .aux_o   (aux_o)
  );

  mc_xor_stage u_xor (
    .sum_i  (casc_o),
    .term_i (pt_val[XT_IDX]),
    .xsel_i (xsel_i),
    .out_o  (xor_o)
  );

endmodule

// File: rtl/mc_sum_cell_chk.sv
module mc_sum_cell_chk #(
  parameter int NUM_TERMS = 5,
  parameter int LINE_W    = 24
) (
  input logic [NUM_TERMS*LINE_W-1:0] tru_mask_i,
  input logic [NUM_TERMS*LINE_W-1:0] cmp_mask_i,
  input logic [NUM_TERMS-1:0]        steer_i,
  input logic [1:0]                  xsel_i,
  input logic                        casc_i,
  input logic                        casc_o,
  input logic                        xor_o,
  input logic [NUM_TERMS-1:0]        aux_o,
  input logic [NUM_TERMS-1:0]        pt_val
);

  always_comb begin
    p_casc_dominates_r8: assert (!casc_i || casc_o);
    p_sum_vs_terms_r5:   assert (casc_o == (casc_i || ((pt_val & ~steer_i) != '0)));
    if (xsel_i == 2'b01) begin
      p_polarity_inv_r6: assert (xor_o == !casc_o);
    end
    if (xsel_i == 2'b00 || xsel_i == 2'b11) begin
      p_polarity_pass_r6: assert (xor_o == casc_o);
    end
    for (int k = 0; k < NUM_TERMS; k++) begin
      p_aux_excl_r4: assert (steer_i[k] || !aux_o[k]);
      p_aux_follow_r4: assert (!steer_i[k] || (aux_o[k] == pt_val[k]));
      if (tru_mask_i[k*LINE_W +: LINE_W] == '0 && cmp_mask_i[k*LINE_W +: LINE_W] == '0) begin
        p_empty_term_r2: assert (pt_val[k]);
      end
    end
  end

endmodule

bind mc_sum_cell mc_sum_cell_chk #(.NUM_TERMS(NUM_TERMS), .LINE_W(LINE_W)) chk_i (
  .tru_mask_i (tru_mask_i),
  .cmp_mask_i (cmp_mask_i),
  .steer_i    (steer_i),
  .xsel_i     (xsel_i),
  .casc_i     (casc_i),
  .casc_o     (casc_o),
  .xor_o      (xor_o),
  .aux_o      (aux_o),
  .pt_val     (pt_val)
);

// File: tb/mc_sum_cell_tb_top.sv
module mc_sum_cell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 5;
  localparam int GW = 16;
  localparam int RW = 8;
  localparam int LW = GW + RW;
  localparam int XT = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [GW-1:0]    glb;
  logic [RW-1:0]    rgn;
  logic [NT*LW-1:0] tm, cm;
  logic [NT-1:0]    steer;
  logic [1:0]       xsel;
  logic             cin;
  logic             cout, xo;
  logic [NT-1:0]    aux;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  mc_sum_cell #(.NUM_TERMS(NT), .GLB_W(GW), .RGN_W(RW), .XT_IDX(XT)) dut_i (
    .glb_i(glb), .rgn_i(rgn), .tru_mask_i(tm), .cmp_mask_i(cm),
    .steer_i(steer), .xsel_i(xsel), .casc_i(cin),
    .casc_o(cout), .xor_o(xo), .aux_o(aux)
  );

  // reference: walk each line bit by bit
  function automatic logic ref_term(int k);
    logic r;
    logic bitv;
    r = 1'b1;
    for (int j = 0; j < LW; j++) begin
      bitv = (j < GW) ? glb[j] : rgn[j-GW];
      if (tm[k*LW+j] && !bitv) r = 1'b0;
      if (cm[k*LW+j] &&  bitv) r = 1'b0;
    end
    return r;
  endfunction

  task automatic apply_and_check(string req);
    logic [NT-1:0] e_aux;
    logic e_sum, e_x, t;
    @(negedge clk);
    #1;
    e_sum = cin;
    e_aux = '0;
    for (int k = 0; k < NT; k++) begin
      t = ref_term(k);
      if (steer[k]) e_aux[k] = t; else e_sum = e_sum | t;
    end
    if (xsel == 2'b01) e_x = ~e_sum;
    else if (xsel == 2'b10) e_x = e_sum ^ ref_term(XT);
    else e_x = e_sum;
    n_vec++;
    if (cout !== e_sum || xo !== e_x || aux !== e_aux) begin
      n_bad++;
      $display("FAIL %s: casc_o=%b xor_o=%b aux_o=%b expected %b %b %b",
               req, cout, xo, aux, e_sum, e_x, e_aux);
    end
  endtask

  task automatic clear_cfg();
    glb = '0; rgn = '0; tm = '0; cm = '0; steer = '0; xsel = 2'b00; cin = 1'b0;
  endtask

  task automatic t_idle();
    clear_cfg();
    apply_and_check("R2 idle empty terms");           // all empty terms -> 1
  endtask

  task automatic t_lines();
    clear_cfg();
    steer = 5'b11110;                                  // only term 0 to sum
    for (int k = 1; k < NT; k++) tm[k*LW +: LW] = '1;  // keep others low-ish
    tm[0*LW + 3] = 1'b1;                               // global bit 3 true
    cm[0*LW + GW + 5] = 1'b1;                          // regional bit 5 complement
    glb[3] = 1'b1; rgn[5] = 1'b0;
    apply_and_check("R1 term true");
    rgn[5] = 1'b1;
    apply_and_check("R1 regional complement");
    rgn[5] = 1'b0; glb[3] = 1'b0;
    apply_and_check("R1 global true");
  endtask

  task automatic t_contra();
    clear_cfg();
    tm[2*LW + 7] = 1'b1; cm[2*LW + 7] = 1'b1;
    steer = 5'b11011;
    glb[7] = 1'b1;
    apply_and_check("R3 contradiction hi");
    glb[7] = 1'b0;
    apply_and_check("R3 contradiction lo");
  endtask

  task automatic t_steer();
    clear_cfg();
    steer = 5'b11111;                                  // all empty terms to aux
    apply_and_check("R4 all aux");
    steer = 5'b01010;
    apply_and_check("R4 mixed");
    for (int k = 0; k < NT; k++) tm[k*LW] = 1'b1;      // all need glb[0]
    steer = '0;
    apply_and_check("R5 sum zero");
    glb[0] = 1'b1;
    apply_and_check("R5 sum one");
  endtask

  task automatic t_xor();
    clear_cfg();
    for (int k = 0; k < NT; k++) tm[k*LW + 1] = 1'b1;
    for (int x = 0; x < 4; x++) begin
      xsel = x[1:0];
      glb[1] = 1'b0;
      apply_and_check(x == 2 ? "R7 xor term" : "R6 polarity");
      glb[1] = 1'b1;
      apply_and_check(x == 2 ? "R7 xor term" : "R6 polarity");
    end
    steer = 5'b10000; xsel = 2'b10;                    // term 4 routed away
    apply_and_check("R7 steered term");
  endtask

  task automatic t_cascade();
    clear_cfg();
    for (int k = 0; k < NT; k++) cm[k*LW + 2] = 1'b1;
    glb[2] = 1'b1;                                     // all terms 0
    cin = 1'b1;
    apply_and_check("R8 cascade in");
    xsel = 2'b01;
    apply_and_check("R8 cascade inverted");
    cin = 1'b0;
    apply_and_check("R8 cascade off");
  endtask

  task automatic t_random();
    for (int v = 0; v < 400; v++) begin
      glb = GW'($urandom); rgn = RW'($urandom);
      for (int k = 0; k < NT; k++) begin
        // sparse masks so terms are 1 often enough
        tm[k*LW +: LW] = LW'($urandom & $urandom & $urandom);
        cm[k*LW +: LW] = LW'($urandom & $urandom & $urandom) & ~tm[k*LW +: LW];
        if ($urandom_range(3) == 0) begin tm[k*LW +: LW] = '0; cm[k*LW +: LW] = '0; end
      end
      steer = NT'($urandom); xsel = 2'($urandom); cin = ($urandom_range(3) == 0);
      apply_and_check("R9 random");
    end
  endtask

  initial begin
    t_idle();
    t_lines();
    t_contra();
    t_steer();
    t_xor();
    t_cascade();
    t_random();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule